// File: doc/BRIEF.md
# Hardwired Micro-Operation Control Sequencer

This block is a small single-accumulator processor driven by hardwired control. A two-bit phase code and a step counter decide which register transfers happen on each clock. The transfers move data between the program counter, the memory address and memory buffer registers, the instruction register and the accumulator. The block also contains an incrementer, an adder and a single-port word memory that allows one access per step. Every instruction passes through a fetch phase. It may then pass through an indirect phase that resolves a pointer, and then through an execute phase whose schedule depends on the opcode. An interrupt phase can follow, which saves the return address at a fixed location and jumps to a fixed service routine.

The instruction word is 16 bits wide. Bit 15 is the indirect flag, bits 14:12 hold the opcode and bits 11:0 hold the word address. A test harness loads the program through a memory side port while reset is held. It then releases reset and watches the debug outputs until the halted flag rises.

Top module: `uop_sequencer`

## Requirements
- R1: A synchronous active-high reset clears PC, IR, R1, the interrupt enable and the halted flag, and puts the phase code on `dbg_cyc` to fetch. The phase codes are 00 fetch, 01 indirect, 10 execute and 11 interrupt.
- R2: Fetch takes three clocks. In the first, MAR takes PC. In the second, MBR takes the memory word and PC increments. In the third, IR takes MBR.
- R3: No register is written and read by another transfer in the same step. MAR is never loaded in the step that reads memory into MBR. PC has at most one source in any step.
- R4: If bit 15 of the fetched word is set, a three-step indirect phase follows. It loads MAR from IR[11:0], reads memory into MBR, then replaces IR[11:0] with MBR[11:0] and moves to execute.
- R5: Opcode 000 (add) takes three execute steps: MAR from the IR address, a memory read into MBR, then R1 becomes R1 + MBR modulo 2^16.
- R6: Opcode 001 (increment, skip if zero) takes four steps: address, read, MBR + 1, then a write of MBR back to memory. In that last step PC also increments when MBR is zero.
- R7: Opcode 010 (branch and save) takes three steps. Step one sends the IR address to MAR and PC to MBR. Step two sends the IR address to PC and writes MBR to memory. Step three increments PC.
- R8: Opcode 111 stops the block in its first execute step. From then on PC, IR, R1, the phase and memory stay frozen, and `irq` is ignored.
- R9: Any other opcode completes execute in one step and changes no register or memory word.
- R10: A pulse on `ien_set` sets the interrupt enable. At the end of execute, the block enters the interrupt phase only if the enable is set and `irq` is high. Otherwise it returns to fetch.
- R11: The interrupt phase takes three steps: PC to MBR, then MAR takes SAVE_ADDR (default 0xFF0) and PC takes ISR_ADDR (default 0xFF1), then MBR is written to memory. Entering the phase clears the enable.
- R12: The step counter restarts at the first step on every phase change.
- R13: The debug port writes memory only while reset is high. `dbg_rdata` always shows the word at `dbg_addr` with no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also opens the debug write path |
| irq | input | 1 | Level-sensitive interrupt request |
| ien_set | input | 1 | Pulse that sets the interrupt enable |
| dbg_we | input | 1 | Debug memory write strobe (effective during reset only) |
| dbg_addr | input | 12 | Debug memory address |
| dbg_wdata | input | 16 | Debug memory write data |
| dbg_rdata | output | 16 | Memory word at dbg_addr |
| halted | output | 1 | Set once a stop instruction has executed |
| dbg_pc | output | 12 | Program counter |
| dbg_ir | output | 16 | Instruction register |
| dbg_r1 | output | 16 | Accumulator |
| dbg_cyc | output | 2 | Current phase code |

## Verification
The checks on interrupt entry assume that `irq` and `ien_set` change only between clock edges and that `ien_set` is not pulsed in the step that ends execute. The stimulus changes inputs only on the falling clock edge and pulses `ien_set` once, during the first fetch step after reset. The checks on the transfer schedule assume the memory holds defined words at every address the program touches. The stimulus preloads all code and data words under reset before any instruction runs.

// File: rtl/uop_pkg.sv
package uop_pkg;

    localparam int WORD_W    = 16;
    localparam int ADDR_W    = 12;
    localparam int OPC_W     = 3;
    localparam int MAX_STEPS = 4;
    localparam int STEP_W    = $clog2(MAX_STEPS);
    localparam int MEM_WORDS = 1 << ADDR_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [STEP_W-1:0] step_t;
    typedef logic [OPC_W-1:0]  opc_t;

    typedef enum logic [1:0] {
        CYC_FETCH = 2'b00,
        CYC_INDIR = 2'b01,
        CYC_EXEC  = 2'b10,
        CYC_INTR  = 2'b11
    } cyc_e;

    localparam opc_t OPC_ADD  = 3'b000;
    localparam opc_t OPC_ISZ  = 3'b001;
    localparam opc_t OPC_BSA  = 3'b010;
    localparam opc_t OPC_HALT = 3'b111;

    // One bit per register transfer the sequencer can request in a step.
    typedef struct packed {
        logic mar_pc;
        logic mar_ir;
        logic mar_save;
        logic mbr_mem;
        logic mbr_pc;
        logic mbr_inc;
        logic ir_mbr;
        logic iraddr_mbr;
        logic pc_inc;
        logic pc_ir;
        logic pc_isr;
        logic pc_skipz;
        logic r1_add;
        logic mem_we;
    } xfer_t;

    function automatic logic word_ind(word_t w);
        return w[WORD_W-1];
    endfunction

    function automatic opc_t word_opc(word_t w);
        return w[WORD_W-2 -: OPC_W];
    endfunction

    function automatic addr_t word_addr(word_t w);
        return w[ADDR_W-1:0];
    endfunction

    function automatic addr_t addr_inc(addr_t a);
        return a + addr_t'(1);
    endfunction

    function automatic word_t word_inc(word_t w);
        return w + word_t'(1);
    endfunction

endpackage

// File: rtl/uop_word_mem.sv
module uop_word_mem
    import uop_pkg::*;
#(
    parameter int WORDS = MEM_WORDS
) (
    input  logic  clk,
    input  logic  load_sel,
    input  logic  core_we,
    input  addr_t core_addr,
    input  word_t core_wdata,
    output word_t core_rdata,
    input  logic  ext_we,
    input  addr_t ext_addr,
    input  word_t ext_wdata,
    output word_t ext_rdata
);

    word_t store [WORDS];

    assign core_rdata = store[core_addr];
    assign ext_rdata  = store[ext_addr];

    // A single write port: the side port owns it while the core is held in reset.
    always_ff @(posedge clk) begin
        if (load_sel) begin
            if (ext_we) begin
                store[ext_addr] <= ext_wdata;
            end
        end else if (core_we) begin
            store[core_addr] <= core_wdata;
        end
    end

endmodule

// File: rtl/uop_phase_ctrl.sv
module uop_phase_ctrl
    import uop_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  opc_t  opc,
    input  logic  fetch_ind,
    input  logic  irq,
    input  logic  ien_set,
    output xfer_t xfer,
    output cyc_e  cyc,
    output step_t step,
    output logic  halted,
    output logic  ien
);

    xfer_t raw;
    logic  last;
    logic  halt_now;
    cyc_e  nxt;

    // Decode of (phase, step, opcode) into the transfer set for this clock.
    always_comb begin
        raw      = '0;
        last     = 1'b0;
        halt_now = 1'b0;
        unique case (cyc)
            CYC_FETCH: begin
                case (step)
                    2'd0:    raw.mar_pc = 1'b1;
                    2'd1: begin
                        raw.mbr_mem = 1'b1;
                        raw.pc_inc  = 1'b1;
                    end
                    default: begin
                        raw.ir_mbr = 1'b1;
                        last       = 1'b1;
                    end
                endcase
            end
            CYC_INDIR: begin
                case (step)
                    2'd0:    raw.mar_ir  = 1'b1;
                    2'd1:    raw.mbr_mem = 1'b1;
                    default: begin
                        raw.iraddr_mbr = 1'b1;
                        last           = 1'b1;
                    end
                endcase
            end
            CYC_EXEC: begin
                case (opc)
                    OPC_ADD: begin
                        case (step)
                            2'd0:    raw.mar_ir  = 1'b1;
                            2'd1:    raw.mbr_mem = 1'b1;
                            default: begin
                                raw.r1_add = 1'b1;
                                last       = 1'b1;
                            end
                        endcase
                    end
                    OPC_ISZ: begin
                        case (step)
                            2'd0:    raw.mar_ir  = 1'b1;
                            2'd1:    raw.mbr_mem = 1'b1;
                            2'd2:    raw.mbr_inc = 1'b1;
                            default: begin
                                raw.mem_we   = 1'b1;
                                raw.pc_skipz = 1'b1;
                                last         = 1'b1;
                            end
                        endcase
                    end
                    OPC_BSA: begin
                        case (step)
                            2'd0: begin
                                raw.mar_ir = 1'b1;
                                raw.mbr_pc = 1'b1;
                            end
                            2'd1: begin
                                raw.pc_ir  = 1'b1;
                                raw.mem_we = 1'b1;
                            end
                            default: begin
                                raw.pc_inc = 1'b1;
                                last       = 1'b1;
                            end
                        endcase
                    end
                    OPC_HALT: halt_now = 1'b1;
                    default:  last     = 1'b1;
                endcase
            end
            CYC_INTR: begin
                case (step)
                    2'd0:    raw.mbr_pc = 1'b1;
                    2'd1: begin
                        raw.mar_save = 1'b1;
                        raw.pc_isr   = 1'b1;
                    end
                    default: begin
                        raw.mem_we = 1'b1;
                        last       = 1'b1;
                    end
                endcase
            end
            default: last = 1'b1;
        endcase
    end

    assign xfer = halted ? '0 : raw;

    // Phase that follows the current one once its last step completes.
    always_comb begin
        unique case (cyc)
            CYC_FETCH: nxt = fetch_ind ? CYC_INDIR : CYC_EXEC;
            CYC_INDIR: nxt = CYC_EXEC;
            CYC_EXEC:  nxt = (ien && irq) ? CYC_INTR : CYC_FETCH;
            default:   nxt = CYC_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc    <= CYC_FETCH;
            step   <= '0;
            halted <= 1'b0;
            ien    <= 1'b0;
        end else if (!halted) begin
            if (halt_now) begin
                halted <= 1'b1;
            end else if (last) begin
                cyc  <= nxt;
                step <= '0;
            end else begin
                step <= step + step_t'(1);
            end
            if (last && (nxt == CYC_INTR)) begin
                ien <= 1'b0;
            end else if (ien_set) begin
                ien <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/uop_datapath.sv
module uop_datapath
    import uop_pkg::*;
#(
    parameter addr_t SAVE_ADDR = 12'hFF0,
    parameter addr_t ISR_ADDR  = 12'hFF1
) (
    input  logic  clk,
    input  logic  rst,
    input  xfer_t xfer,
    input  word_t mem_rdata,
    output addr_t pc,
    output addr_t mar,
    output word_t mbr,
    output word_t ir,
    output word_t r1
);

    logic mbr_zero;
    assign mbr_zero = (mbr == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            mar <= '0;
        end else if (xfer.mar_pc) begin
            mar <= pc;
        end else if (xfer.mar_ir) begin
            mar <= word_addr(ir);
        end else if (xfer.mar_save) begin
            mar <= SAVE_ADDR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mbr <= '0;
        end else if (xfer.mbr_mem) begin
            mbr <= mem_rdata;
        end else if (xfer.mbr_pc) begin
            mbr <= word_t'(pc);
        end else if (xfer.mbr_inc) begin
            mbr <= word_inc(mbr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ir <= '0;
        end else if (xfer.ir_mbr) begin
            ir <= mbr;
        end else if (xfer.iraddr_mbr) begin
            ir <= {ir[WORD_W-1:ADDR_W], word_addr(mbr)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (xfer.pc_isr) begin
            pc <= ISR_ADDR;
        end else if (xfer.pc_ir) begin
            pc <= word_addr(ir);
        end else if (xfer.pc_inc || (xfer.pc_skipz && mbr_zero)) begin
            pc <= addr_inc(pc);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r1 <= '0;
        end else if (xfer.r1_add) begin
            r1 <= r1 + mbr;
        end
    end

endmodule

// File: rtl/uop_sequencer.sv
module uop_sequencer
    import uop_pkg::*;
#(
    parameter logic [11:0] SAVE_ADDR = 12'hFF0,
    parameter logic [11:0] ISR_ADDR  = 12'hFF1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        irq,
    input  logic        ien_set,
    input  logic        dbg_we,
    input  logic [11:0] dbg_addr,
    input  logic [15:0] dbg_wdata,
    output logic [15:0] dbg_rdata,
    output logic        halted,
    output logic [11:0] dbg_pc,
    output logic [15:0] dbg_ir,
    output logic [15:0] dbg_r1,
    output logic [1:0]  dbg_cyc
);

    xfer_t xfer_w;
    cyc_e  cyc_w;
    step_t step_w;
    logic  ien_w;
    addr_t pc_w;
    addr_t mar_w;
    word_t mbr_w;
    word_t ir_w;
    word_t r1_w;
    word_t rdata_w;

    uop_phase_ctrl ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .opc       (word_opc(ir_w)),
        .fetch_ind (word_ind(mbr_w)),
        .irq       (irq),
        .ien_set   (ien_set),
        .xfer      (xfer_w),
        .cyc       (cyc_w),
        .step      (step_w),
        .halted    (halted),
        .ien       (ien_w)
    );

    uop_datapath #(
        .SAVE_ADDR (SAVE_ADDR),
        .ISR_ADDR  (ISR_ADDR)
    ) dp_i (
        .clk       (clk),
        .rst       (rst),
        .xfer      (xfer_w),
        .mem_rdata (rdata_w),
        .pc        (pc_w),
        .mar       (mar_w),
        .mbr       (mbr_w),
        .ir        (ir_w),
        .r1        (r1_w)
    );

    uop_word_mem #(
        .WORDS (MEM_WORDS)
    ) mem_i (
        .clk        (clk),
        .load_sel   (rst),
        .core_we    (xfer_w.mem_we),
        .core_addr  (mar_w),
        .core_wdata (mbr_w),
        .core_rdata (rdata_w),
        .ext_we     (dbg_we),
        .ext_addr   (dbg_addr),
        .ext_wdata  (dbg_wdata),
        .ext_rdata  (dbg_rdata)
    );

    assign dbg_pc  = pc_w;
    assign dbg_ir  = ir_w;
    assign dbg_r1  = r1_w;
    assign dbg_cyc = cyc_w;

endmodule

// File: rtl/uop_sequencer_chk.sv
module uop_sequencer_chk
    import uop_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        irq,
    input logic [1:0]  cyc,
    input step_t       step,
    input logic        halted,
    input logic        ien,
    input xfer_t       xfer
);

    logic mbr_written;
    logic mbr_consumed;
    assign mbr_written  = xfer.mbr_mem | xfer.mbr_pc | xfer.mbr_inc;
    assign mbr_consumed = xfer.ir_mbr | xfer.iraddr_mbr | xfer.mem_we | xfer.r1_add | xfer.pc_skipz;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cyc == 2'b00) && (step == '0) && !ien && !halted);

    assert_mbr_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
        !(mbr_written && mbr_consumed));

    assert_mar_before_read_R2: assert property (@(posedge clk) disable iff (rst)
        xfer.mbr_mem |-> !(xfer.mar_pc || xfer.mar_ir || xfer.mar_save));

    assert_pc_one_source_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({xfer.pc_inc, xfer.pc_ir, xfer.pc_isr, xfer.pc_skipz}));

    assert_indirect_exit_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(cyc) == 2'b01 && cyc != 2'b01) |-> cyc == 2'b10);

    assert_halt_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && $stable(cyc) && $stable(step));

    assert_intr_entry_R10: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'b11 && $past(cyc) != 2'b11) |-> $past(cyc) == 2'b10 && $past(ien) && $past(irq));

    assert_intr_clears_en_R11: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'b11 && $past(cyc) != 2'b11) |-> !ien);

    assert_step_restart_R12: assert property (@(posedge clk) disable iff (rst)
        (cyc != $past(cyc)) |-> step == '0);

endmodule

bind uop_sequencer uop_sequencer_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .irq    (irq),
    .cyc    (cyc_w),
    .step   (step_w),
    .halted (halted),
    .ien    (ien_w),
    .xfer   (xfer_w)
);

// File: tb/uop_sequencer_tb_top.sv
`timescale 1ns/1ps
module uop_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst, irq, ien_set, dbg_we;
    logic [11:0] dbg_addr;
    logic [15:0] dbg_wdata, dbg_rdata;
    logic        halted;
    logic [11:0] dbg_pc;
    logic [15:0] dbg_ir, dbg_r1;
    logic [1:0]  dbg_cyc;

    always #10 clk = ~clk;

    uop_sequencer dut_i (
        .clk(clk), .rst(rst), .irq(irq), .ien_set(ien_set),
        .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
        .halted(halted), .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_r1(dbg_r1), .dbg_cyc(dbg_cyc)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Behavioural reference state, updated once per rising edge.
    logic [11:0] m_pc, m_mar;
    logic [15:0] m_mbr, m_ir, m_r1;
    int          m_ph, m_st;
    bit          m_ien, m_halt;
    logic [15:0] m_mem [4096];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_clock();
        logic [11:0] pc_n, mar_n;
        logic [15:0] mbr_n, ir_n, r1_n;
        int  op, nph;
        bit  fin, stop;
        if (rst) begin
            m_pc = 0; m_mar = 0; m_mbr = 0; m_ir = 0; m_r1 = 0;
            m_ph = 0; m_st = 0; m_ien = 0; m_halt = 0;
            if (dbg_we) m_mem[dbg_addr] = dbg_wdata;
            return;
        end
        if (m_halt) return;
        pc_n = m_pc; mar_n = m_mar; mbr_n = m_mbr; ir_n = m_ir; r1_n = m_r1;
        op = int'(m_ir[14:12]); nph = 0; fin = 0; stop = 0;
        if (m_ph == 0) begin
            if (m_st == 0) mar_n = m_pc;
            else if (m_st == 1) begin mbr_n = m_mem[m_mar]; pc_n = m_pc + 1; end
            else begin ir_n = m_mbr; fin = 1; nph = m_mbr[15] ? 1 : 2; end
        end else if (m_ph == 1) begin
            if (m_st == 0) mar_n = m_ir[11:0];
            else if (m_st == 1) mbr_n = m_mem[m_mar];
            else begin ir_n = {m_ir[15:12], m_mbr[11:0]}; fin = 1; nph = 2; end
        end else if (m_ph == 2) begin
            nph = (m_ien && irq) ? 3 : 0;
            if (op == 0) begin
                if (m_st == 0) mar_n = m_ir[11:0];
                else if (m_st == 1) mbr_n = m_mem[m_mar];
                else begin r1_n = m_r1 + m_mbr; fin = 1; end
            end else if (op == 1) begin
                if (m_st == 0) mar_n = m_ir[11:0];
                else if (m_st == 1) mbr_n = m_mem[m_mar];
                else if (m_st == 2) mbr_n = m_mbr + 1;
                else begin
                    m_mem[m_mar] = m_mbr;
                    if (m_mbr == 16'h0000) pc_n = m_pc + 1;
                    fin = 1;
                end
            end else if (op == 2) begin
                if (m_st == 0) begin mar_n = m_ir[11:0]; mbr_n = {4'h0, m_pc}; end
                else if (m_st == 1) begin pc_n = m_ir[11:0]; m_mem[m_mar] = m_mbr; end
                else begin pc_n = m_pc + 1; fin = 1; end
            end else if (op == 7) begin
                stop = 1;
            end else begin
                fin = 1;
            end
        end else begin
            nph = 0;
            if (m_st == 0) mbr_n = {4'h0, m_pc};
            else if (m_st == 1) begin mar_n = 12'hFF0; pc_n = 12'hFF1; end
            else begin m_mem[m_mar] = m_mbr; fin = 1; end
        end
        if (fin && m_ph == 2 && nph == 3) m_ien = 0;
        else if (ien_set) m_ien = 1;
        if (stop) m_halt = 1;
        else if (fin) begin m_ph = nph; m_st = 0; end
        else m_st = m_st + 1;
        m_pc = pc_n; m_mar = mar_n; m_mbr = mbr_n; m_ir = ir_n; m_r1 = r1_n;
    endtask

    task automatic compare();
        logic [1:0] ph;
        ph = 2'(m_ph);
        check("R1 R2 R4 R12 per-step state {pc,cyc,halted,ir,r1}",
              {17'h0, dbg_pc, dbg_cyc, halted, dbg_ir, dbg_r1},
              {17'h0, m_pc, ph, m_halt, m_ir, m_r1});
    endtask

    task automatic tick();
        @(posedge clk);
        model_clock();
        @(negedge clk);
        compare();
    endtask

    task automatic load(input logic [11:0] a, input logic [15:0] d);
        dbg_we = 1'b1; dbg_addr = a; dbg_wdata = d;
        tick();
        dbg_we = 1'b0;
    endtask

    task automatic peek(input string tag, input logic [11:0] a, input logic [15:0] exp);
        dbg_addr = a;
        #1;
        check(tag, {48'h0, dbg_rdata}, {48'h0, exp});
    endtask

    task automatic run_to_halt();
        for (int i = 0; i < 600 && !halted; i++) tick();
        for (int i = 0; i < 12; i++) tick();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #(20ns * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog R8 actual=running expected=halted");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) m_mem[i] = 16'h0000;
        rst = 1'b1; irq = 1'b0; ien_set = 1'b0; dbg_we = 1'b0;
        dbg_addr = 12'h000; dbg_wdata = 16'h0000;
        tick(); tick();
        check("R1 reset pc", {52'h0, dbg_pc}, 64'h0);
        check("R1 reset cycle code fetch", {62'h0, dbg_cyc}, 64'h0);
        check("R1 reset halted low", {63'h0, halted}, 64'h0);

        // Program A: interrupts requested but never enabled.
        load(12'h000, 16'h0100);  // add 0x100
        load(12'h001, 16'h8101);  // add indirect via 0x101
        load(12'h002, 16'h1103);  // isz 0x103 (no skip)
        load(12'h003, 16'h1103);  // isz 0x103 (skip)
        load(12'h004, 16'h7000);  // stop, must be skipped
        load(12'h005, 16'h2200);  // branch and save to 0x200
        load(12'h201, 16'h9104);  // isz indirect via 0x104 (skip)
        load(12'h202, 16'h7000);  // skipped
        load(12'h203, 16'h3000);  // undefined opcode
        load(12'h204, 16'h0106);  // add 0xFFFF
        load(12'h205, 16'h7000);  // stop
        load(12'h100, 16'h0005);
        load(12'h101, 16'h0102);
        load(12'h102, 16'h0007);
        load(12'h103, 16'hFFFE);
        load(12'h104, 16'h0105);
        load(12'h105, 16'hFFFF);
        load(12'h106, 16'hFFFF);
        load(12'h200, 16'h0000);
        load(12'hFF0, 16'hAAAA);
        load(12'h300, 16'h1234);
        peek("R13 word written under reset", 12'h100, 16'h0005);

        @(negedge clk);
        rst = 1'b0; irq = 1'b1;
        run_to_halt();
        check("R8 halted after stop", {63'h0, halted}, 64'h1);
        check("R5 R9 accumulator 5+7+0xFFFF", {48'h0, dbg_r1}, 64'h000B);
        check("R6 R8 final pc after skips", {52'h0, dbg_pc}, 64'h206);
        peek("R6 isz result wraps to zero", 12'h103, 16'h0000);
        peek("R4 R6 isz through pointer", 12'h105, 16'h0000);
        peek("R7 return address saved", 12'h200, 16'h0006);
        peek("R10 no save while enable clear", 12'hFF0, 16'hAAAA);
        peek("R9 undefined opcode word intact", 12'h203, 16'h3000);

        dbg_we = 1'b1; dbg_addr = 12'h300; dbg_wdata = 16'hBEEF;
        tick();
        dbg_we = 1'b0;
        peek("R13 write ignored out of reset", 12'h300, 16'h1234);

        // Program B: enabled interrupt with irq held high.
        @(negedge clk);
        rst = 1'b1; irq = 1'b0;
        tick();
        load(12'h000, 16'h0100);  // add 0x100
        load(12'h001, 16'h7000);  // stop (never reached)
        load(12'hFF1, 16'h0100);  // service routine: add 0x100
        load(12'hFF2, 16'h7000);  // stop
        load(12'hFF0, 16'h0000);
        load(12'h100, 16'h0005);
        check("R1 reset clears accumulator", {48'h0, dbg_r1}, 64'h0);

        @(negedge clk);
        rst = 1'b0; irq = 1'b1; ien_set = 1'b1;
        tick();
        ien_set = 1'b0;
        run_to_halt();
        check("R10 two adds ran", {48'h0, dbg_r1}, 64'h000A);
        check("R11 single entry, pc after routine stop", {52'h0, dbg_pc}, 64'hFF3);
        peek("R11 pc saved at save address", 12'hFF0, 16'h0001);
        peek("R11 code after return untouched", 12'h001, 16'h7000);

        summary();
        $finish;
    end

endmodule